// File: doc/BRIEF.md
# Inbound Address Decode Windows

This block translates addresses arriving from the link side into a target on the on-chip fabric. Software programs up to six decode windows through a small register bus. Each window has a control word, a base and a remap value. A single aperture, defined by a power-of-two size and a 64-bit base, is checked first and gates every window lookup.

For every address presented with `in_valid`, the block registers a result one cycle later. On a hit, the result holds the target identifier, the attribute byte and the translated 32-bit address of the winning window. On a miss, `out_miss` is raised and all result fields are zero. Windows may overlap. When they do, the lowest-numbered window that hits is used.

Top module: `inbw_decode`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock. When `out_valid` is 0, `out_hit` and `out_miss` are both 0.
- R2: Window control word fields are: bits 31:16 size mask in 64 KiB pages, bits 15:8 attribute, bits 7:4 target, bit 0 enable. A window hits when it is enabled and `(in_addr[31:16] & ~mask) == base[31:16]`. On a hit, `out_target` and `out_attr` come from that window.
- R3: When several windows hit, the lowest-numbered one supplies the result.
- R4: If the winning window's remap field is zero, `out_addr = in_addr[31:0]`. Otherwise `out_addr[31:16] = (remap & ~mask) | (in_addr[31:16] & mask)` and `out_addr[15:0] = in_addr[15:0]`.
- R5: The aperture matches when three conditions hold: aperture control bit 0 is set, `in_addr[63:32]` equals the upper-base register, and `(in_addr[31:16] & ~apmask)` equals `(lower_base[31:16] & ~apmask)`. When the aperture does not match, the result is a miss whatever the windows hold.
- R6: A miss gives `out_miss`=1 and `out_hit`=0, with target, attribute and address all zero.
- R7: Register map (byte offsets):
  - Windows 0..4: control at 0x20+16n, base at +4, remap at +0xC.
  - Window 5: control at 0x80, base at 0x84, remap at 0x8C.
  - Aperture: control at 0x04, lower base at 0x08, upper base at 0x0C.
  - Base and remap read back with bits 15:0 zero. Window control reads back with bits 3:1 zero.
  - Unmapped offsets read as zero, and writes to them change nothing.
- R8: The lower aperture base stores bits 31:16 only. Its bits 3:0 always read 0xC, and bits 15:4 read 0.
- R9: The aperture size field (control bits 31:16) is stored as a contiguous low mask: every bit at or below the highest written 1 reads as 1. Bits 15:1 of the aperture control read zero.
- R10: Writing zero to a window's control, base and remap registers removes it from decoding. Addresses it used to claim then fall to the next hitting window, or miss.
- R11: After reset, all registers read zero except the lower aperture base, which reads 0xC. `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| in_valid | input | 1 | Inbound address valid |
| in_addr | input | 64 | Inbound address |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_hit | output | 1 | A window claimed the address |
| out_miss | output | 1 | No window, or the aperture, claimed the address |
| out_target | output | 4 | Target identifier of the winning window |
| out_attr | output | 8 | Attribute byte of the winning window |
| out_addr | output | 32 | Translated address |

## Verification
The following are checked by assertions on every cycle:
- the one-cycle valid timing and the hit/miss exclusivity;
- aperture gating, which forces a miss;
- all-zero fields on a miss;
- the selection vector being one-hot and picking the lowest hitting window;
- the fixed flag nibble of the lower aperture base.

Only the bench scenarios can show the remaining behaviours:
- the field packing of control words;
- the translated address under remap and pass-through;
- mask filling of the aperture size;
- readback masking and ignored writes to unmapped offsets;
- clearing a window.

These are checked against independent bench arithmetic over directed corners and randomly programmed, overlapping windows.

// File: rtl/inbw_pkg.sv
package inbw_pkg;
  localparam int PG_W          = 16;
  localparam int OFF_AP_CTRL   = 4;
  localparam int OFF_BAR_LO    = 8;
  localparam int OFF_BAR_HI    = 12;
  localparam int OFF_WIN_FIRST = 32;
  localparam int WIN_STRIDE    = 16;
  localparam int OFF_WIN_LAST  = 128;
  localparam int SUB_CTRL      = 0;
  localparam int SUB_BASE      = 4;
  localparam int SUB_REMAP     = 12;
  localparam logic [3:0] BAR_FLAGS = 4'hC;

  typedef struct packed {
    logic [PG_W-1:0] mask;
    logic [7:0]      attr;
    logic [3:0]      tgt;
    logic            en;
  } win_cfg_t;

  function automatic win_cfg_t unpack_ctrl(input logic [31:0] w);
    win_cfg_t c;
    c.mask = w[31:16];
    c.attr = w[15:8];
    c.tgt  = w[7:4];
    c.en   = w[0];
    return c;
  endfunction

  function automatic logic [31:0] pack_ctrl(input win_cfg_t c);
    return {c.mask, c.attr, c.tgt, 3'b000, c.en};
  endfunction

  // Every bit at or below the highest set bit becomes 1.
  function automatic logic [PG_W-1:0] fill_mask(input logic [PG_W-1:0] v);
    logic [PG_W-1:0] r;
    r = v;
    for (int i = PG_W - 2; i >= 0; i--) r[i] = r[i] | r[i+1];
    return r;
  endfunction

  function automatic logic win_match(input win_cfg_t c, input logic [PG_W-1:0] base,
                                     input logic [PG_W-1:0] page);
    return c.en && ((page & ~c.mask) == base);
  endfunction

  function automatic logic ap_match(input logic en, input logic [PG_W-1:0] mask,
                                    input logic [PG_W-1:0] lo, input logic [31:0] hi,
                                    input logic [63:0] a);
    return en && (a[63:32] == hi) && ((a[31:16] & ~mask) == (lo & ~mask));
  endfunction

  function automatic logic [31:0] remap_addr(input logic [31:0] a, input logic [PG_W-1:0] mask,
                                             input logic [PG_W-1:0] rmp);
    if (rmp == '0) return a;
    return {(rmp & ~mask) | (a[31:16] & mask), a[15:0]};
  endfunction
endpackage

// File: rtl/inbw_regs.sv
module inbw_regs
  import inbw_pkg::*;
#(
  parameter int NWIN = 6,
  parameter int RAW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output win_cfg_t        cfg   [NWIN],
  output logic [PG_W-1:0] base  [NWIN],
  output logic [PG_W-1:0] rmp   [NWIN],
  output logic            ap_en,
  output logic [PG_W-1:0] ap_mask,
  output logic [PG_W-1:0] bar_lo,
  output logic [31:0]     bar_hi
);
  localparam logic [RAW-1:0] A_APC = RAW'(OFF_AP_CTRL);
  localparam logic [RAW-1:0] A_BLO = RAW'(OFF_BAR_LO);
  localparam logic [RAW-1:0] A_BHI = RAW'(OFF_BAR_HI);

  function automatic logic [RAW-1:0] woff(input int w);
    return (w < NWIN - 1) ? RAW'(OFF_WIN_FIRST + WIN_STRIDE * w) : RAW'(OFF_WIN_LAST);
  endfunction

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[w]  <= '0;
        base[w] <= '0;
        rmp[w]  <= '0;
      end else if (wr_en) begin
        if (reg_addr == woff(w) + RAW'(SUB_CTRL))  cfg[w]  <= unpack_ctrl(wdata);
        if (reg_addr == woff(w) + RAW'(SUB_BASE))  base[w] <= wdata[31:16];
        if (reg_addr == woff(w) + RAW'(SUB_REMAP)) rmp[w]  <= wdata[31:16];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_en   <= 1'b0;
      ap_mask <= '0;
      bar_lo  <= '0;
      bar_hi  <= '0;
    end else if (wr_en) begin
      if (reg_addr == A_APC) begin
        ap_en   <= wdata[0];
        ap_mask <= fill_mask(wdata[31:16]);
      end
      if (reg_addr == A_BLO) bar_lo <= wdata[31:16];
      if (reg_addr == A_BHI) bar_hi <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (reg_addr == A_APC) rdata = {ap_mask, 15'b0, ap_en};
    if (reg_addr == A_BLO) rdata = {bar_lo, 12'b0, BAR_FLAGS};
    if (reg_addr == A_BHI) rdata = bar_hi;
    for (int w = 0; w < NWIN; w++) begin
      if (reg_addr == woff(w) + RAW'(SUB_CTRL))  rdata = pack_ctrl(cfg[w]);
      if (reg_addr == woff(w) + RAW'(SUB_BASE))  rdata = {base[w], 16'b0};
      if (reg_addr == woff(w) + RAW'(SUB_REMAP)) rdata = {rmp[w], 16'b0};
    end
  end
endmodule

// File: rtl/inbw_match.sv
module inbw_match
  import inbw_pkg::*;
#(
  parameter int NWIN = 6,
  localparam int IW  = $clog2(NWIN)
) (
  input  win_cfg_t        cfg  [NWIN],
  input  logic [PG_W-1:0] base [NWIN],
  input  logic [PG_W-1:0] page,
  output logic [NWIN-1:0] hit_vec,
  output logic [NWIN-1:0] sel_vec,
  output logic [IW-1:0]   sel_idx,
  output logic            any_hit
);
  for (genvar w = 0; w < NWIN; w++) begin : g_hit
    assign hit_vec[w] = win_match(cfg[w], base[w], page);
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    sel_vec = '0;
    sel_idx = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (hit_vec[w] && !found) begin
        sel_vec[w] = 1'b1;
        sel_idx    = IW'(w);
        found      = 1'b1;
      end
    end
    any_hit = found;
  end
endmodule

// File: rtl/inbw_decode.sv
module inbw_decode
  import inbw_pkg::*;
#(
  parameter int NWIN = 6,
  parameter int RAW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           in_valid,
  input  logic [63:0]    in_addr,
  output logic           out_valid,
  output logic           out_hit,
  output logic           out_miss,
  output logic [3:0]     out_target,
  output logic [7:0]     out_attr,
  output logic [31:0]    out_addr
);
  localparam int IW = $clog2(NWIN);

  win_cfg_t        cfg  [NWIN];
  logic [PG_W-1:0] base [NWIN];
  logic [PG_W-1:0] rmp  [NWIN];
  logic            ap_en;
  logic [PG_W-1:0] ap_mask;
  logic [PG_W-1:0] bar_lo;
  logic [31:0]     bar_hi;

  logic [NWIN-1:0] hit_vec;
  logic [NWIN-1:0] sel_vec;
  logic [IW-1:0]   sel_idx;
  logic            any_hit;
  logic            ap_hit;
  logic            take;
  win_cfg_t        selc;

  inbw_regs #(.NWIN(NWIN), .RAW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .reg_addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg), .base(base), .rmp(rmp),
    .ap_en(ap_en), .ap_mask(ap_mask), .bar_lo(bar_lo), .bar_hi(bar_hi)
  );

  inbw_match #(.NWIN(NWIN)) u_match (
    .cfg(cfg), .base(base), .page(in_addr[31:16]),
    .hit_vec(hit_vec), .sel_vec(sel_vec), .sel_idx(sel_idx), .any_hit(any_hit)
  );

  assign ap_hit = ap_match(ap_en, ap_mask, bar_lo, bar_hi, in_addr);
  assign take   = in_valid && ap_hit && any_hit;
  assign selc   = cfg[sel_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_miss   <= 1'b0;
      out_target <= '0;
      out_attr   <= '0;
      out_addr   <= '0;
    end else begin
      out_valid  <= in_valid;
      out_hit    <= take;
      out_miss   <= in_valid && !take;
      out_target <= take ? selc.tgt : '0;
      out_attr   <= take ? selc.attr : '0;
      out_addr   <= take ? remap_addr(in_addr[31:0], selc.mask, rmp[sel_idx]) : '0;
    end
  end
endmodule

// File: rtl/inbw_checker.sv
module inbw_checker #(
  parameter int NWIN = 6,
  parameter int RAW  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            ap_hit,
  input logic [NWIN-1:0] hit_vec,
  input logic [NWIN-1:0] sel_vec,
  input logic            any_hit,
  input logic            out_valid,
  input logic            out_hit,
  input logic            out_miss,
  input logic [3:0]      out_target,
  input logic [7:0]      out_attr,
  input logic [31:0]     out_addr,
  input logic [RAW-1:0]  reg_addr,
  input logic [31:0]     reg_rdata
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R1
  AST_NO_RESULT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> (!out_hit && !out_miss)); // R1
  AST_HIT_MISS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_hit != out_miss)); // R6
  AST_APERTURE_GATES: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !ap_hit) |=> out_miss); // R5
  AST_MISS_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n) out_miss |-> (out_target == 4'h0 && out_attr == 8'h00 && out_addr == 32'h0)); // R6
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel_vec)); // R3
  AST_SEL_LOWEST: assert property (@(posedge clk) disable iff (!rst_n) any_hit |-> (sel_vec == (hit_vec & (~hit_vec + NWIN'(1))))); // R3
  AST_SEL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !any_hit |-> (sel_vec == '0 && hit_vec == '0)); // R3
  AST_BAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (reg_addr == RAW'(8)) |-> (reg_rdata[3:0] == 4'hC)); // R8
endmodule

bind inbw_decode inbw_checker #(.NWIN(NWIN), .RAW(RAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ap_hit(ap_hit),
  .hit_vec(hit_vec), .sel_vec(sel_vec), .any_hit(any_hit),
  .out_valid(out_valid), .out_hit(out_hit), .out_miss(out_miss),
  .out_target(out_target), .out_attr(out_attr), .out_addr(out_addr),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/sim_inbw_decode.sv
module sim_inbw_decode;
  localparam int NWIN = 6;
  localparam int RAW  = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n = 1'b0;
  logic           reg_wr = 1'b0;
  logic [RAW-1:0] reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic           in_valid = 1'b0;
  logic [63:0]    in_addr = '0;
  logic           out_valid, out_hit, out_miss;
  logic [3:0]     out_target;
  logic [7:0]     out_attr;
  logic [31:0]    out_addr;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_ctrl [NWIN];
  logic [31:0] m_base [NWIN];
  logic [31:0] m_rmp  [NWIN];
  logic [31:0] m_apc, m_blo, m_bhi;

  inbw_decode #(.NWIN(NWIN), .RAW(RAW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_hit(out_hit), .out_miss(out_miss),
    .out_target(out_target), .out_attr(out_attr), .out_addr(out_addr)
  );

  function automatic int bwoff(input int w);
    if (w == NWIN - 1) return 128;
    return 32 + 16 * w;
  endfunction

  function automatic logic [15:0] pow2_fill(input logic [15:0] v);
    int h;
    h = -1;
    for (int i = 0; i < 16; i++) if (v[i]) h = i;
    if (h < 0) return 16'h0;
    return 16'((32'd1 << (h + 1)) - 1);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = RAW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 4)  m_apc = {pow2_fill(d[31:16]), 15'b0, d[0]};
    if (a == 8)  m_blo = {d[31:16], 16'h000C};
    if (a == 12) m_bhi = d;
    for (int w = 0; w < NWIN; w++) begin
      if (a == bwoff(w))      m_ctrl[w] = d & 32'hFFFF_FFF1;
      if (a == bwoff(w) + 4)  m_base[w] = d & 32'hFFFF_0000;
      if (a == bwoff(w) + 12) m_rmp[w]  = d & 32'hFFFF_0000;
    end
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = RAW'(a);
    #1;
    chk(tag, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  task automatic lookup(input logic [63:0] a, input string tag);
    logic        hit;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [31:0] oa;
    logic [15:0] hi, msk, rhi;
    logic        ap_ok;
    hi = a[31:16];
    ap_ok = m_apc[0] && (a[63:32] == m_bhi) &&
            (((hi ^ m_blo[31:16]) & ~m_apc[31:16]) == 16'h0);
    hit = 1'b0; tgt = '0; attr = '0; oa = '0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      msk = m_ctrl[w][31:16];
      if (m_ctrl[w][0] && (((hi | msk) ^ msk) == m_base[w][31:16]) && ap_ok) begin
        hit = 1'b1; tgt = m_ctrl[w][7:4]; attr = m_ctrl[w][15:8];
        rhi = m_rmp[w][31:16];
        if (rhi == 16'h0) oa = a[31:0];
        else oa = {hi ^ ((hi ^ rhi) & ~msk), a[15:0]};
      end
    end
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    chk(tag, {18'h0, out_valid, out_hit, out_miss, out_target, out_attr, out_addr},
             {18'h0, 1'b1, hit, !hit, tgt, attr, oa});
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int w = 0; w < NWIN; w++) begin m_ctrl[w] = 0; m_base[w] = 0; m_rmp[w] = 0; end
    m_apc = 0; m_blo = 32'hC; m_bhi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    @(negedge clk);
    chk("R11 out_valid after reset", {63'h0, out_valid}, 64'h0);
    rd(4, 32'h0, "R11 aperture ctrl reset");
    rd(8, 32'hC, "R11 lower base reset");
    rd(12, 32'h0, "R11 upper base reset");
    rd(32, 32'h0, "R11 window0 ctrl reset");
    rd(140, 32'h0, "R11 window5 remap reset");

    // R7 / R8 / R9 readback
    wr(32, 32'hFFFF_FFFF);  rd(32, 32'hFFFF_FFF1, "R7 ctrl readback");
    wr(36, 32'h1234_5678);  rd(36, 32'h1234_0000, "R7 base readback");
    wr(44, 32'hABCD_EF01);  rd(44, 32'hABCD_0000, "R7 remap readback");
    wr(128, 32'h0003_7751); rd(128, 32'h0003_7751, "R7 window5 ctrl group");
    wr(132, 32'h00C0_FFFF); rd(132, 32'h00C0_0000, "R7 window5 base group");
    wr(8, 32'h5555_5553);   rd(8, 32'h5555_000C, "R8 lower base flags");
    wr(4, 32'h0005_0001);   rd(4, 32'h0007_0001, "R9 size fill small");
    wr(4, 32'h8000_FFFE);   rd(4, 32'hFFFF_0000, "R9 size fill top bit");
    wr(16, 32'hFFFF_FFFF);  rd(16, 32'h0, "R7 unmapped offset reads zero");
    rd(40, 32'h0, "R7 gap inside window group");
    rd(32, 32'hFFFF_FFF1, "R7 unmapped write left window0 intact");
    for (int w = 0; w < NWIN; w++) begin wr(bwoff(w), 0); wr(bwoff(w) + 4, 0); wr(bwoff(w) + 12, 0); end

    // full aperture
    wr(4, 32'hFFFF_0001); wr(8, 0); wr(12, 0);
    @(negedge clk);
    chk("R1 idle before lookups", {63'h0, out_valid}, 64'h0);

    // R2 basic hit and miss
    wr(48, 32'h000F_5A31); wr(52, 32'h0010_0000);
    lookup(64'h0000_0000_0013_4567, "R2 window1 hit");
    lookup(64'h0000_0000_0020_0000, "R6 miss outside windows");
    wr(80, 32'h0000_0070); wr(84, 32'h0050_0000);
    lookup(64'h0000_0000_0050_0000, "R2 disabled window misses");
    @(negedge clk);
    chk("R1 valid drops after lookup", {63'h0, out_valid}, 64'h0);

    // R3 priority
    wr(32, 32'h00FF_1111); wr(36, 32'h0000_0000);
    lookup(64'h0000_0000_0013_4567, "R3 window0 wins overlap");
    // R10 clear
    wr(32, 0); wr(36, 0); wr(44, 0);
    lookup(64'h0000_0000_0013_4567, "R10 cleared window falls to next");
    lookup(64'h0000_0000_0000_1234, "R10 cleared window area misses");

    // R4 remap
    wr(60, 32'hAB00_0000);
    lookup(64'h0000_0000_0013_4567, "R4 remap replaces upper bits");
    wr(60, 32'h0000_FFFF);
    lookup(64'h0000_0000_001E_89AB, "R4 zero remap passes through");

    // R5 aperture
    wr(8, 32'h0010_0000); wr(4, 32'h0003_0001);
    lookup(64'h0000_0000_0013_4567, "R5 inside aperture");
    lookup(64'h0000_0000_0014_0000, "R5 beyond aperture size");
    lookup(64'h0000_0001_0013_4567, "R5 upper address mismatch");
    wr(4, 32'h0003_0000);
    lookup(64'h0000_0000_0013_4567, "R5 aperture disabled");

    // random phase
    wr(4, 32'hFFFF_0001); wr(8, 0); wr(12, 0);
    for (int r = 0; r < 20; r++) begin
      for (int w = 0; w < NWIN; w++) begin
        logic [15:0] msk, b;
        msk = 16'((32'd1 << ($urandom % 7)) - 1);
        if ($urandom % 8 == 0) msk = 16'($urandom);
        b = 16'($urandom & 32'h00F0) & ~msk;
        if ($urandom % 10 == 0) b = 16'($urandom);
        wr(bwoff(w), {msk, 8'($urandom), 4'($urandom), 3'($urandom), 1'(($urandom % 4) != 0)});
        wr(bwoff(w) + 4, {b, 16'($urandom)});
        wr(bwoff(w) + 12, ($urandom % 2 == 0) ? 32'h0 : $urandom);
      end
      for (int k = 0; k < 20; k++) begin
        int w;
        logic [15:0] hi;
        logic [63:0] a;
        w = int'($urandom % NWIN);
        hi = m_base[w][31:16] | (16'($urandom) & m_ctrl[w][31:16]);
        if ($urandom % 5 == 0) hi = 16'($urandom);
        a = {32'h0, hi, 16'($urandom)};
        if ($urandom % 16 == 0) a[63:32] = 32'h1;
        lookup(a, "R2 R3 R4 random lookup");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule